// File: doc/BRIEF.md
# Sinc Decimation Filter with Result Integrator

This block turns a fast stream of input samples into a slow stream of signed result words. Each input is either one bit from a sigma-delta modulator, read as +1 or -1, or a 16-bit two's-complement word from a parallel source. The samples go through a cascaded integrator-comb Sinc filter. Its order and decimation ratio are chosen at run time.

The filter outputs that survive settling are summed by a second integrator over a programmable count. Each sum is scaled down by an arithmetic right shift and corrected by a signed offset. It is then clipped to 24 bits and presented with a one-cycle valid strobe.

A conversion begins with a start pulse, which clears all filter state and latches the configuration. In single mode the block delivers one result and then goes idle. In continuous mode it delivers results until the next start.

Top module: `sinc_dec_filter`

## Requirements
- R1: With `par_sel_i`=1 each sample is `data_i` read as 16-bit two's complement. With `par_sel_i`=0 it is `bit_i`, where 1 means +1 and 0 means -1.
- R2: `ord_i` selects the filter order K from 1 to 5. A value of 0 acts as order 1, and the values 6 and 7 act as order 5.
- R3: The filter ratio is R = `fosr_i`+1 (1..1024). After every R-th accepted sample the filter produces one value. That value is the input, zero before start, passed through K cascaded moving sums of length R, taken at that sample.
- R4: Each result is the sum of I = `iosr_i`+1 consecutive retained filter values (I is 1..256).
- R5: The first K-1 filter values after start are discarded. The first result therefore completes with accepted sample R*(K+I-1), and later results complete every R*I samples. `res_vld_o` is high for one cycle, two clock edges after the edge that accepts the completing sample.
- R6: A result equals (sum >>> `shift_i`) - `offset_i`, where `offset_i` is 24-bit signed. `res_o` changes only when `res_vld_o` is high.
- R7: The result saturates to the range -8388608..8388607.
- R8: With `cont_i`=0 at start, exactly one result is produced. After it, `vld_i` is ignored until the next start.
- R9: With `cont_i`=1, results repeat for as long as samples arrive. Cycles with `vld_i` low have no effect on the values.
- R10: `start_i` clears all filter state and latches order, ratios, input select and mode. A sample offered in the same cycle as `start_i` is dropped.
- R11: After reset `res_o` is 0 and `res_vld_o` is 0. Before any start, samples produce no result.
- R12: Order 5 at ratio 1024 with full-scale inputs is computed exactly, with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a conversion: clear state, latch configuration |
| cont_i | input | 1 | 1 selects continuous mode, 0 selects single mode |
| par_sel_i | input | 1 | 1 selects the parallel word, 0 selects the serial bit |
| bit_i | input | 1 | Serial modulator bit |
| data_i | input | 16 | Parallel sample, two's complement |
| vld_i | input | 1 | Sample strobe |
| ord_i | input | 3 | Filter order |
| fosr_i | input | 10 | Filter ratio minus one |
| iosr_i | input | 8 | Integrator ratio minus one |
| shift_i | input | 5 | Right shift of the summed value |
| offset_i | input | 24 | Signed offset subtracted after the shift |
| res_o | output | 24 | Signed result |
| res_vld_o | output | 1 | Result strobe, one cycle |

## Verification
The bench builds the block with its default parameters: order up to 5, a 10-bit filter ratio field, an 8-bit integrator ratio field and 24-bit results. With these defaults the widest case, order 5 at ratio 1024 with full-scale positive, negative and unit inputs, can be reached in a few thousand cycles per run. That case shows the 66-bit integrators wrapping and still giving exact results. Small ratios such as 1, 2 and 4 keep each result close behind its input. This lets the order clamp, the settling count, the restart precedence and both saturation limits each be checked against a direct moving-sum model within a short run.

// File: rtl/sinc_dec_pkg.sv
package sinc_dec_pkg;
  localparam int DW      = 16;
  localparam int MAX_ORD = 5;
  localparam int ORD_W   = 3;
  localparam int FOSR_W  = 10;
  localparam int IOSR_W  = 8;
  localparam int SH_W    = 5;
  localparam int OUT_W   = 24;
  localparam int ACC_W   = DW + MAX_ORD * FOSR_W;
  localparam int SUM_W   = ACC_W + IOSR_W;
endpackage

// File: rtl/sinc_cic_core.sv
module sinc_cic_core #(
  parameter int DW      = sinc_dec_pkg::DW,
  parameter int MAX_ORD = sinc_dec_pkg::MAX_ORD,
  parameter int ORD_W   = sinc_dec_pkg::ORD_W,
  parameter int FOSR_W  = sinc_dec_pkg::FOSR_W,
  parameter int ACC_W   = sinc_dec_pkg::ACC_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    smp_vld_i,
  input  logic signed [DW-1:0]    smp_i,
  input  logic [ORD_W-1:0]        ord_i,
  input  logic [FOSR_W-1:0]       fosr_i,
  output logic signed [ACC_W-1:0] filt_o,
  output logic                    filt_vld_o
);
  logic signed [ACC_W-1:0] integ_q  [MAX_ORD];
  logic signed [ACC_W-1:0] integ_d  [MAX_ORD];
  logic signed [ACC_W-1:0] dly_q    [MAX_ORD];
  logic signed [ACC_W-1:0] comb_in  [MAX_ORD];
  logic signed [ACC_W-1:0] comb_out [MAX_ORD];
  logic signed [ACC_W-1:0] int_sel, out_sel, smp_ext;
  logic [FOSR_W-1:0] cnt_q;
  logic [ORD_W-1:0]  settle_q;

  assign smp_ext = {{(ACC_W-DW){smp_i[DW-1]}}, smp_i};

  // integrators chained within one cycle, combs run at the decimated rate
  for (genvar g = 0; g < MAX_ORD; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign integ_d[g] = integ_q[g] + smp_ext;
      assign comb_in[g] = int_sel;
    end else begin : g_rest
      assign integ_d[g] = integ_q[g] + integ_d[g-1];
      assign comb_in[g] = comb_out[g-1];
    end
    assign comb_out[g] = comb_in[g] - dly_q[g];
  end

  always_comb begin
    int_sel = '0;
    out_sel = '0;
    for (int k = 0; k < MAX_ORD; k++) begin
      if (ORD_W'(k + 1) == ord_i) begin
        int_sel = integ_d[k];
        out_sel = comb_out[k];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < MAX_ORD; k++) begin
        integ_q[k] <= '0;
        dly_q[k]   <= '0;
      end
      cnt_q      <= '0;
      settle_q   <= '0;
      filt_o     <= '0;
      filt_vld_o <= 1'b0;
    end else if (clr_i) begin
      for (int k = 0; k < MAX_ORD; k++) begin
        integ_q[k] <= '0;
        dly_q[k]   <= '0;
      end
      cnt_q      <= '0;
      settle_q   <= '0;
      filt_vld_o <= 1'b0;
    end else begin
      filt_vld_o <= 1'b0;
      if (smp_vld_i) begin
        for (int k = 0; k < MAX_ORD; k++) integ_q[k] <= integ_d[k];
        if (cnt_q == fosr_i) begin
          cnt_q <= '0;
          for (int k = 0; k < MAX_ORD; k++) dly_q[k] <= comb_in[k];
          if (settle_q == ord_i - ORD_W'(1)) begin
            filt_o     <= out_sel;
            filt_vld_o <= 1'b1;
          end else begin
            settle_q <= settle_q + ORD_W'(1);
          end
        end else begin
          cnt_q <= cnt_q + FOSR_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sinc_post.sv
module sinc_post #(
  parameter int ACC_W  = sinc_dec_pkg::ACC_W,
  parameter int IOSR_W = sinc_dec_pkg::IOSR_W,
  parameter int SUM_W  = sinc_dec_pkg::SUM_W,
  parameter int OUT_W  = sinc_dec_pkg::OUT_W,
  parameter int SH_W   = sinc_dec_pkg::SH_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic signed [ACC_W-1:0] filt_i,
  input  logic                    filt_vld_i,
  input  logic [IOSR_W-1:0]       iosr_i,
  input  logic [SH_W-1:0]         shift_i,
  input  logic signed [OUT_W-1:0] offset_i,
  output logic                    fire_o,
  output logic signed [OUT_W-1:0] res_o,
  output logic                    res_vld_o
);
  localparam logic signed [SUM_W:0] MAX_V = (SUM_W+1)'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [SUM_W:0] MIN_V = -MAX_V - 1;

  logic signed [SUM_W-1:0] acc_q, sum_d, shifted;
  logic signed [SUM_W:0]   diff;
  logic signed [OUT_W-1:0] sat;
  logic [IOSR_W-1:0]       icnt_q;

  assign sum_d   = acc_q + {{(SUM_W-ACC_W){filt_i[ACC_W-1]}}, filt_i};
  assign shifted = sum_d >>> shift_i;
  assign diff    = {shifted[SUM_W-1], shifted}
                 - {{(SUM_W+1-OUT_W){offset_i[OUT_W-1]}}, offset_i};
  assign fire_o  = filt_vld_i && (icnt_q == iosr_i);

  always_comb begin
    if (diff > MAX_V)      sat = MAX_V[OUT_W-1:0];
    else if (diff < MIN_V) sat = MIN_V[OUT_W-1:0];
    else                   sat = diff[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      icnt_q    <= '0;
      res_o     <= '0;
      res_vld_o <= 1'b0;
    end else if (clr_i) begin
      acc_q     <= '0;
      icnt_q    <= '0;
      res_vld_o <= 1'b0;
    end else begin
      res_vld_o <= 1'b0;
      if (fire_o) begin
        acc_q     <= '0;
        icnt_q    <= '0;
        res_o     <= sat;
        res_vld_o <= 1'b1;
      end else if (filt_vld_i) begin
        acc_q  <= sum_d;
        icnt_q <= icnt_q + IOSR_W'(1);
      end
    end
  end
endmodule

// File: rtl/sinc_dec_filter.sv
module sinc_dec_filter #(
  parameter int DW      = sinc_dec_pkg::DW,
  parameter int MAX_ORD = sinc_dec_pkg::MAX_ORD,
  parameter int ORD_W   = sinc_dec_pkg::ORD_W,
  parameter int FOSR_W  = sinc_dec_pkg::FOSR_W,
  parameter int IOSR_W  = sinc_dec_pkg::IOSR_W,
  parameter int SH_W    = sinc_dec_pkg::SH_W,
  parameter int OUT_W   = sinc_dec_pkg::OUT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cont_i,
  input  logic              par_sel_i,
  input  logic              bit_i,
  input  logic [DW-1:0]     data_i,
  input  logic              vld_i,
  input  logic [ORD_W-1:0]  ord_i,
  input  logic [FOSR_W-1:0] fosr_i,
  input  logic [IOSR_W-1:0] iosr_i,
  input  logic [SH_W-1:0]   shift_i,
  input  logic [OUT_W-1:0]  offset_i,
  output logic [OUT_W-1:0]  res_o,
  output logic              res_vld_o
);
  localparam int ACC_W = DW + MAX_ORD * FOSR_W;
  localparam int SUM_W = ACC_W + IOSR_W;

  logic run_q, cont_q, par_q, fire, filt_vld;
  logic [ORD_W-1:0]  ord_q;
  logic [FOSR_W-1:0] fosr_q;
  logic [IOSR_W-1:0] iosr_q;
  logic signed [DW-1:0]    smp;
  logic signed [ACC_W-1:0] filt;

  function automatic logic [ORD_W-1:0] clamp_ord(input logic [ORD_W-1:0] o);
    if (o == '0) return ORD_W'(1);
    if (int'(o) > MAX_ORD) return ORD_W'(MAX_ORD);
    return o;
  endfunction

  // serial bit 1 -> +1, 0 -> -1
  assign smp = par_q ? data_i : {{(DW-1){~bit_i}}, 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      cont_q <= 1'b0;
      par_q  <= 1'b0;
      ord_q  <= ORD_W'(1);
      fosr_q <= '0;
      iosr_q <= '0;
    end else if (start_i) begin
      run_q  <= 1'b1;
      cont_q <= cont_i;
      par_q  <= par_sel_i;
      ord_q  <= clamp_ord(ord_i);
      fosr_q <= fosr_i;
      iosr_q <= iosr_i;
    end else if (fire && !cont_q) begin
      run_q <= 1'b0;
    end
  end

  sinc_cic_core #(
    .DW(DW), .MAX_ORD(MAX_ORD), .ORD_W(ORD_W), .FOSR_W(FOSR_W), .ACC_W(ACC_W)
  ) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (start_i),
    .smp_vld_i  (vld_i && run_q),
    .smp_i      (smp),
    .ord_i      (ord_q),
    .fosr_i     (fosr_q),
    .filt_o     (filt),
    .filt_vld_o (filt_vld)
  );

  sinc_post #(
    .ACC_W(ACC_W), .IOSR_W(IOSR_W), .SUM_W(SUM_W), .OUT_W(OUT_W), .SH_W(SH_W)
  ) u_post (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (start_i),
    .filt_i     (filt),
    .filt_vld_i (filt_vld && run_q),
    .iosr_i     (iosr_q),
    .shift_i    (shift_i),
    .offset_i   (offset_i),
    .fire_o     (fire),
    .res_o      (res_o),
    .res_vld_o  (res_vld_o)
  );
endmodule

// File: rtl/sinc_dec_filter_chk.sv
module sinc_dec_filter_chk #(
  parameter int OUT_W   = 24,
  parameter int ORD_W   = 3,
  parameter int MAX_ORD = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [OUT_W-1:0] res_o,
  input logic             res_vld_o,
  input logic             filt_vld,
  input logic             run_q,
  input logic             cont_q,
  input logic [ORD_W-1:0] ord_q
);
  p_order_clamp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (ord_q >= ORD_W'(1) && ord_q <= ORD_W'(MAX_ORD)));

  p_vld_after_filt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o |-> $past(filt_vld && run_q));

  p_res_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(res_o) |-> res_vld_o);

  p_single_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_o && !cont_q) |-> !run_q);

  p_start_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!res_vld_o && !filt_vld));
endmodule

bind sinc_dec_filter sinc_dec_filter_chk #(
  .OUT_W(OUT_W), .ORD_W(ORD_W), .MAX_ORD(MAX_ORD)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .res_o     (res_o),
  .res_vld_o (res_vld_o),
  .filt_vld  (filt_vld),
  .run_q     (run_q),
  .cont_q    (cont_q),
  .ord_q     (ord_q)
);

// File: tb/sinc_dec_filter_tb_top.sv
module sinc_dec_filter_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk; // 10 ns period, 100 MHz

  logic rst_n, start, cont, par, bit_v, vld, res_vld;
  logic [15:0] data;
  logic [2:0]  ord;
  logic [9:0]  fosr;
  logic [7:0]  iosr;
  logic [4:0]  sh;
  logic [23:0] off, res;

  int errors = 0;
  int checks = 0;
  longint smp [0:2047];
  longint cur [0:2047];
  longint nxt [0:2047];
  longint exp_v [0:511];
  longint got [0:511];
  int n_exp;
  int ng = 0;

  sinc_dec_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cont_i(cont), .par_sel_i(par),
    .bit_i(bit_v), .data_i(data), .vld_i(vld), .ord_i(ord), .fosr_i(fosr),
    .iosr_i(iosr), .shift_i(sh), .offset_i(off), .res_o(res), .res_vld_o(res_vld)
  );

  always @(negedge clk) begin
    if (res_vld && ng < 512) begin
      got[ng] = longint'($signed(res));
      ng++;
    end
  end

  task automatic chk(input string req, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic longint sat24(input longint v);
    if (v > 64'sd8388607) return 64'sd8388607;
    if (v < -64'sd8388608) return -64'sd8388608;
    return v;
  endfunction

  // direct model: K cascaded length-R moving sums, then grouping and scaling
  task automatic model(input int n, input int k, input int r, input int i_r,
                       input int shv, input longint offv, input bit single);
    longint acc;
    int cnt_i;
    for (int j = 0; j < n; j++) cur[j] = smp[j];
    for (int s = 0; s < k; s++) begin
      for (int j = 0; j < n; j++)
        nxt[j] = (j > 0 ? nxt[j-1] : 0) + cur[j] - (j >= r ? cur[j-r] : 0);
      for (int j = 0; j < n; j++) cur[j] = nxt[j];
    end
    n_exp = 0; acc = 0; cnt_i = 0;
    for (int m = 1; m * r <= n; m++) begin
      if (m >= k && !(single && n_exp > 0)) begin
        acc += cur[m*r-1];
        cnt_i++;
        if (cnt_i == i_r) begin
          exp_v[n_exp] = sat24((acc >>> shv) - offv);
          n_exp++;
          acc = 0; cnt_i = 0;
        end
      end
    end
  endtask

  task automatic fill(input int n, input bit serial, input longint cval, input bit use_c);
    logic [15:0] t;
    for (int j = 0; j < n; j++) begin
      t = 16'($urandom);
      if (use_c) smp[j] = cval;
      else if (serial) smp[j] = t[0] ? 1 : -1;
      else smp[j] = longint'($signed(t));
    end
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; ng = 0;
  endtask

  task automatic drive(input int n, input bit gap);
    for (int j = 0; j < n; j++) begin
      vld = 1'b1; data = smp[j][15:0]; bit_v = (smp[j] > 0);
      @(negedge clk);
      if (gap && (j % 3 == 2)) begin vld = 1'b0; @(negedge clk); end
    end
    vld = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic set_cfg(input int k_cfg, input int r, input int i_r, input bit p,
                         input bit c, input int shv, input longint offv);
    ord = 3'(k_cfg); fosr = 10'(r - 1); iosr = 8'(i_r - 1);
    par = p; cont = c; sh = 5'(shv); off = 24'(offv);
  endtask

  task automatic compare(input string req);
    chk({req, " result count"}, ng, n_exp);
    for (int j = 0; j < n_exp && j < ng; j++) chk(req, got[j], exp_v[j]);
  endtask

  task automatic run_case(input string req, input int k_cfg, input int k_mod, input int r,
                          input int i_r, input bit p, input bit c, input int shv,
                          input longint offv, input int n, input bit gap);
    set_cfg(k_cfg, r, i_r, p, c, shv, offv);
    do_start();
    drive(n, gap);
    model(n, k_mod, r, i_r, shv, offv, !c);
    compare(req);
  endtask

  task automatic t_reset();
    chk("R11 res_o after reset", longint'(res), 0);
    chk("R11 res_vld_o after reset", longint'(res_vld), 0);
    fill(20, 1'b0, 0, 1'b0);
    set_cfg(1, 1, 1, 1'b1, 1'b1, 0, 0);
    ng = 0;
    drive(20, 1'b0);
    chk("R11 no result before start", ng, 0);
  endtask

  task automatic t_serial();
    fill(200, 1'b1, 0, 1'b0);
    run_case("R1 R3 R9 serial K3 R8 gaps", 3, 3, 8, 1, 1'b0, 1'b1, 0, 0, 200, 1'b1);
    fill(600, 1'b1, 0, 1'b0);
    run_case("R1 R4 R6 serial K4 R16 I2", 4, 4, 16, 2, 1'b0, 1'b1, 3, -50, 600, 1'b0);
  endtask

  task automatic t_parallel();
    fill(300, 1'b0, 0, 1'b0);
    run_case("R4 R6 parallel K5 R4 I3", 5, 5, 4, 3, 1'b1, 1'b1, 4, 100, 300, 1'b1);
    fill(40, 1'b0, 0, 1'b0);
    run_case("R3 ratio one passthrough", 1, 1, 1, 1, 1'b1, 1'b1, 0, 0, 40, 1'b0);
  endtask

  task automatic t_order_clamp();
    fill(80, 1'b0, 0, 1'b0);
    run_case("R2 order 0 acts as 1", 0, 1, 4, 2, 1'b1, 1'b1, 2, 0, 80, 1'b0);
    fill(80, 1'b0, 0, 1'b0);
    run_case("R2 order 7 acts as 5", 7, 5, 2, 1, 1'b1, 1'b1, 6, 0, 80, 1'b0);
  endtask

  task automatic t_saturate();
    fill(100, 1'b0, 32767, 1'b1);
    run_case("R7 positive clip", 3, 3, 16, 1, 1'b1, 1'b1, 0, 0, 100, 1'b0);
    fill(100, 1'b0, -32768, 1'b1);
    run_case("R7 negative clip", 3, 3, 16, 1, 1'b1, 1'b1, 0, 0, 100, 1'b0);
    fill(10, 1'b0, 0, 1'b1);
    run_case("R7 R6 offset drives clip", 1, 1, 1, 1, 1'b1, 1'b1, 0, -8388608, 10, 1'b0);
    fill(10, 1'b0, 0, 1'b1);
    run_case("R6 offset in range", 1, 1, 1, 1, 1'b1, 1'b1, 0, 8388607, 10, 1'b0);
  endtask

  task automatic t_single();
    fill(40, 1'b0, 0, 1'b0);
    run_case("R8 single mode one result", 2, 2, 4, 2, 1'b1, 1'b0, 1, 7, 40, 1'b0);
  endtask

  task automatic t_latency();
    int first_e, second_e;
    first_e = -1; second_e = -1;
    set_cfg(2, 4, 2, 1'b1, 1'b1, 0, 0);
    do_start();
    for (int e = 1; e <= 40; e++) begin
      vld = 1'b1; data = 16'd1;
      @(negedge clk);
      if (res_vld) begin
        if (first_e < 0) first_e = e;
        else if (second_e < 0) second_e = e;
      end
    end
    vld = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5 first result timing", first_e, 13);
    chk("R5 result spacing", second_e, 21);
  endtask

  task automatic t_restart();
    fill(30, 1'b0, 0, 1'b0);
    set_cfg(2, 4, 1, 1'b1, 1'b1, 0, 0);
    do_start();
    drive(30, 1'b0);
    fill(40, 1'b0, 0, 1'b0);
    @(negedge clk); start = 1'b1; vld = 1'b1; data = 16'd30000;
    @(negedge clk); start = 1'b0; vld = 1'b0; ng = 0;
    ord = 3'd5; fosr = 10'd0;
    drive(40, 1'b0);
    model(40, 2, 4, 1, 0, 0, 1'b0);
    compare("R10 restart drops sample, config latched");
  endtask

  task automatic t_full_scale(input longint val, input longint expv, input string req);
    set_cfg(5, 1024, 1, 1'b1, 1'b0, 31, 0);
    do_start();
    for (int j = 0; j < 5130; j++) begin
      vld = 1'b1; data = val[15:0];
      @(negedge clk);
    end
    vld = 1'b0;
    repeat (4) @(negedge clk);
    chk({req, " count"}, ng, 1);
    chk(req, got[0], expv);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; cont = 1'b0; par = 1'b0; bit_v = 1'b0; vld = 1'b0;
    data = '0; ord = 3'd1; fosr = '0; iosr = '0; sh = '0; off = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_serial();
    t_parallel();
    t_order_clamp();
    t_saturate();
    t_single();
    t_latency();
    t_restart();
    t_full_scale(1, 524288, "R12 order5 ratio1024 unit input");
    t_full_scale(-1, -524288, "R12 order5 ratio1024 negative unit");
    t_full_scale(-32768, -8388608, "R12 R7 order5 ratio1024 full scale");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule